// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block collects the interrupt conditions of one UART channel, ranks them into four priority levels and presents the result to the host two ways: a single active-high interrupt line and an 8-bit status word. The host reads the status word with a one-cycle read strobe. The low nibble of the word names the most urgent enabled source, and the top two bits show whether the channel runs in FIFO mode.

Two kinds of source exist. Receive line errors, receive data available and receive time-out are levels: they stay active for as long as the rest of the channel holds the condition, and only servicing that condition removes them. Transmit holding empty and modem status change are events. Each is captured on the rising edge of its flag and held until it is serviced. A status read services only the source that the word reports at that moment, so repeated reads walk down through the lower-priority events one at a time. A write to the transmit holding register also clears the transmit event.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the status word is 8'h01 and `irq` is 0.
- R2: Bits 7:6 of the status word are 2'b11 when `fifo_mode` is 1 and 2'b00 when it is 0. Bits 5:4 are always 0.
- R3: Bit 0 is 0 when an enabled source is pending and 1 otherwise. Bits 3:0 carry one of these codes: line error 4'b0110, receive data 4'b0100, receive time-out 4'b1100, transmit empty 4'b0010, modem change 4'b0000, nothing pending 4'b0001.
- R4: The priority order is line error, then receive data, then transmit empty, then modem change. Receive data and time-out share one level, and receive data is reported when both are active.
- R5: A read clears a pending transmit-empty or modem event only when the status word shows that event in the cycle of the read. Any lower source still pending is reported in the following cycle.
- R6: Line error, receive data and time-out are not cleared by a read. They are reported for as long as their input stays high.
- R7: The transmit-empty event is set by a 0-to-1 transition of `thr_empty` and cleared by `thr_write`. A `thr_empty` that stays high sets it only once.
- R8: The modem event is set by a 0-to-1 transition of `modem_chg` and is cleared only by a read that reports it.
- R9: `src_en` bit 0 enables line error, bit 1 enables receive data and time-out, bit 2 enables transmit empty and bit 3 enables modem change. A disabled source is left out of both `irq` and the code. A captured event stays held while its source is disabled and is reported again once it is enabled.
- R10: The status word and `irq` are registered and reflect the inputs and event state one clock later. `irq` is 1 exactly when bit 0 of the status word is 0.
- R11: If a new rising edge of an event flag arrives in the same cycle as a clear of that event, the event stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | FIFO mode indication for bits 7:6 |
| src_en | input | 4 | Source enables: line, receive, transmit, modem |
| line_err | input | 1 | Receive line error condition (level) |
| rx_rdy | input | 1 | Receive data available (level) |
| rx_tmo | input | 1 | Receive time-out condition (level) |
| thr_empty | input | 1 | Transmit holding register empty flag |
| modem_chg | input | 1 | Modem status change flag |
| thr_write | input | 1 | Write strobe to transmit holding register |
| isr_rd | input | 1 | Status word read strobe |
| irq | output | 1 | Interrupt request, active high |
| isr | output | 8 | Interrupt status word |

## Verification
Most faults in the captured event bits are visible at the ports one clock after the cycle that should have changed them. Examples are a lost rising edge, a clear aimed at the wrong source, or a clear that loses to a coincident new edge. Each one either shows an extra code or drops a code in the walk of successive reads down the priority ladder. A wrong ranking or a wrong mask shows at once as the wrong nibble, or as `irq` disagreeing with bit 0. The bench raises every source together and steps through them with reads. It then compares every cycle of a long random run against a model built from the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int SRC_EN_W = 4;
    localparam int ISR_W    = 8;
    localparam int ID_W     = 4;
    localparam int N_EVT    = 2;

    // event slot indices
    localparam int EVT_THRE  = 0;
    localparam int EVT_MODEM = 1;

    // identification codes for status bits 3:0
    localparam logic [ID_W-1:0] ID_LINE  = 4'b0110;
    localparam logic [ID_W-1:0] ID_RXRDY = 4'b0100;
    localparam logic [ID_W-1:0] ID_RXTMO = 4'b1100;
    localparam logic [ID_W-1:0] ID_THRE  = 4'b0010;
    localparam logic [ID_W-1:0] ID_MODEM = 4'b0000;
    localparam logic [ID_W-1:0] ID_NONE  = 4'b0001;

    typedef struct packed {
        logic line;
        logic rxrdy;
        logic rxtmo;
        logic thre;
        logic modem;
    } irq_src_t;

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch
    import uart_irq_pkg::*;
#(
    parameter int N = N_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_nxt
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (flag[i] && !st_q.prev[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (clr[i]) begin
                st_d.pend[i] = 1'b0;
            end
        end
        st_d.prev = flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q   = st_q.pend;
    assign pend_nxt = st_d.pend;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_src_t        act,
    output logic [ID_W-1:0] id,
    output logic            any
);

    always_comb begin
        if (act.line) begin
            id = ID_LINE;
        end else if (act.rxrdy) begin
            id = ID_RXRDY;
        end else if (act.rxtmo) begin
            id = ID_RXTMO;
        end else if (act.thre) begin
            id = ID_THRE;
        end else if (act.modem) begin
            id = ID_MODEM;
        end else begin
            id = ID_NONE;
        end
    end

    assign any = |act;

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_mode,
    input  logic [SRC_EN_W-1:0] src_en,
    input  logic                line_err,
    input  logic                rx_rdy,
    input  logic                rx_tmo,
    input  logic                thr_empty,
    input  logic                modem_chg,
    input  logic                thr_write,
    input  logic                isr_rd,
    output logic                irq,
    output logic [ISR_W-1:0]    isr
);

    localparam int FIFO_BITS = ISR_W - ID_W - 2;

    typedef struct packed {
        logic [ISR_W-1:0] isr;
        logic             irq;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [N_EVT-1:0] evt_flag, evt_clr, evt_q, evt_nxt;
    irq_src_t         act;
    logic [ID_W-1:0]  id;
    logic             any;

    assign evt_flag[EVT_THRE]  = thr_empty;
    assign evt_flag[EVT_MODEM] = modem_chg;

    always_comb begin
        evt_clr[EVT_THRE]  = thr_write || (isr_rd && st_q.isr[ID_W-1:0] == ID_THRE);
        evt_clr[EVT_MODEM] = isr_rd && st_q.isr[ID_W-1:0] == ID_MODEM;
    end

    irq_evt_latch #(.N(N_EVT)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (evt_flag),
        .clr      (evt_clr),
        .pend_q   (evt_q),
        .pend_nxt (evt_nxt)
    );

    always_comb begin
        act.line  = line_err  && src_en[0];
        act.rxrdy = rx_rdy    && src_en[1];
        act.rxtmo = rx_tmo    && src_en[1];
        act.thre  = evt_nxt[EVT_THRE]  && src_en[2];
        act.modem = evt_nxt[EVT_MODEM] && src_en[3];
    end

    irq_prio_enc u_enc (
        .act (act),
        .id  (id),
        .any (any)
    );

    always_comb begin
        st_d     = st_q;
        st_d.isr = {{FIFO_BITS{fifo_mode}}, 2'b00, id};
        st_d.irq = any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.isr <= {{(ISR_W-ID_W){1'b0}}, ID_NONE};
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isr = st_q.isr;
    assign irq = st_q.irq;

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode,
    input logic [3:0] src_en,
    input logic       line_err,
    input logic       rx_rdy,
    input logic       irq,
    input logic [7:0] isr
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_IRQ_VS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !isr[0]);                                                  // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        isr[5:4] == 2'b00);                                               // R2
    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> isr[7:6] == {2{$past(fifo_mode)}});                   // R2
    AST_LEGAL_ID: assert property (@(posedge clk) disable iff (!rst_n)
        isr[3:0] inside {4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000, 4'b0001}); // R3
    AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(line_err && src_en[0]) |-> isr[3:0] == 4'b0110); // R4
    AST_RDY_OVER_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(rx_rdy && src_en[1] && !(line_err && src_en[0]))
        |-> isr[3:0] == 4'b0100);                                         // R4

endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .src_en    (src_en),
    .line_err  (line_err),
    .rx_rdy    (rx_rdy),
    .irq       (irq),
    .isr       (isr)
);

// File: tb/uart_irq_id_test.sv
`timescale 1ns/1ps
module uart_irq_id_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b1;
    logic [3:0] src_en = 4'hF;
    logic       line_err = 0, rx_rdy = 0, rx_tmo = 0, thr_empty = 0, modem_chg = 0;
    logic       thr_write = 0, isr_rd = 0;
    logic       irq;
    logic [7:0] isr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_irq_id uut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .src_en(src_en),
        .line_err(line_err), .rx_rdy(rx_rdy), .rx_tmo(rx_tmo),
        .thr_empty(thr_empty), .modem_chg(modem_chg), .thr_write(thr_write),
        .isr_rd(isr_rd), .irq(irq), .isr(isr)
    );

    // reference model built from the requirements
    logic [7:0] m_isr;
    logic       m_irq, m_tx, m_md, m_txp, m_mdp;

    function automatic logic [3:0] code_of(logic l, logic r, logic t, logic x, logic m);
        if (l) return 4'b0110;
        if (r) return 4'b0100;
        if (t) return 4'b1100;
        if (x) return 4'b0010;
        if (m) return 4'b0000;
        return 4'b0001;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_isr = 8'h01; m_irq = 0; m_tx = 0; m_md = 0; m_txp = 0; m_mdp = 0;
        end else begin
            logic ctx, cmd, l, r, t, x, m;
            ctx = thr_write || (isr_rd && m_isr[3:0] == 4'b0010);
            cmd = isr_rd && m_isr[3:0] == 4'b0000;
            if (thr_empty && !m_txp) m_tx = 1; else if (ctx) m_tx = 0;
            if (modem_chg && !m_mdp) m_md = 1; else if (cmd) m_md = 0;
            m_txp = thr_empty; m_mdp = modem_chg;
            l = line_err && src_en[0];
            r = rx_rdy && src_en[1];
            t = rx_tmo && src_en[1];
            x = m_tx && src_en[2];
            m = m_md && src_en[3];
            m_isr = {{2{fifo_mode}}, 2'b00, code_of(l, r, t, x, m)};
            m_irq = l | r | t | x | m;
        end
    end

    task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd_pulse();
        isr_rd = 1; step(); isr_rd = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout exp finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        chk("R1 reset", {irq, isr}, {1'b0, 8'h01});
        rst_n = 1;
        step();
        chk("R1 idle", {irq, isr}, {1'b0, 8'hC1});

        // all sources at once, then walk down
        line_err = 1; rx_rdy = 1; rx_tmo = 1; thr_empty = 1; modem_chg = 1;
        step(); modem_chg = 0;
        chk("R4 line first", {irq, isr}, {1'b1, 8'hC6});
        rd_pulse();
        chk("R6 line kept", {irq, isr}, {1'b1, 8'hC6});
        line_err = 0; step();
        chk("R4 rdy over tmo", {irq, isr}, {1'b1, 8'hC4});
        rd_pulse();
        chk("R6 rdy kept", {irq, isr}, {1'b1, 8'hC4});
        rx_rdy = 0; step();
        chk("R3 tmo code", {irq, isr}, {1'b1, 8'hCC});
        rx_tmo = 0; step();
        chk("R4 thre", {irq, isr}, {1'b1, 8'hC2});
        rd_pulse();
        chk("R5 modem next", {irq, isr}, {1'b1, 8'hC0});
        rd_pulse();
        chk("R8 modem cleared", {irq, isr}, {1'b0, 8'hC1});
        step();
        chk("R7 level no reset", {irq, isr}, {1'b0, 8'hC1});

        // THR write clears
        thr_empty = 0; step(); thr_empty = 1; step();
        chk("R7 edge sets", {irq, isr}, {1'b1, 8'hC2});
        thr_write = 1; step(); thr_write = 0;
        chk("R7 write clears", {irq, isr}, {1'b0, 8'hC1});

        // masking keeps event
        src_en = 4'b1011; thr_empty = 0; step(); thr_empty = 1; step();
        chk("R9 masked", {irq, isr}, {1'b0, 8'hC1});
        rd_pulse();
        src_en = 4'hF; step();
        chk("R9 reappears", {irq, isr}, {1'b1, 8'hC2});

        // set beats clear
        thr_empty = 0; step();
        chk("R11 still set", {irq, isr}, {1'b1, 8'hC2});
        thr_empty = 1; thr_write = 1; step(); thr_write = 0;
        chk("R11 edge wins", {irq, isr}, {1'b1, 8'hC2});

        // non-FIFO mode and modem survives read of higher source
        fifo_mode = 0; modem_chg = 1; step(); modem_chg = 0;
        chk("R2 fifo off", {irq, isr}, {1'b1, 8'h02});
        rd_pulse();
        chk("R5 lower shown", {irq, isr}, {1'b1, 8'h00});
        rd_pulse();
        chk("R8 read clears modem", {irq, isr}, {1'b0, 8'h01});
        fifo_mode = 1;

        // random run against model
        for (int i = 0; i < 4000; i++) begin
            chk("R10 model", {irq, isr}, {m_irq, m_isr});
            line_err  = ($urandom % 8) == 0;
            rx_rdy    = ($urandom % 5) == 0;
            rx_tmo    = ($urandom % 6) == 0;
            thr_empty = ($urandom % 3) != 0;
            modem_chg = ($urandom % 4) == 0;
            thr_write = ($urandom % 9) == 0;
            isr_rd    = ($urandom % 3) == 0;
            if (($urandom % 50) == 0) src_en = 4'($urandom);
            if (($urandom % 200) == 0) fifo_mode = ~fifo_mode;
            step();
        end
        chk("R10 final", {irq, isr}, {m_irq, m_isr});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule